// File: doc/BRIEF.md
# Programmable Skew Clock Output Matrix

This block is a digital model of a clock fan-out stage with four output sections. It runs on a fast time-unit tick. From that tick it builds a nominal clock whose period is a fixed number of ticks. A three-level range select picks that number.

Each section has two three-level function selects, and each select arrives as a 2-bit code. The two selects choose one of nine output functions. Every section drives a pair of outputs that always carry the same waveform.

- Sections 0 and 1 shift the nominal clock by a signed skew in steps of one tick.
- Sections 2 and 3 shift it in steps of two ticks.
- Sections 2 and 3 also give their two extreme codes to special modes: divide-by-2 and divide-by-4 in section 2, divide-by-2 and inversion in section 3.

Select changes and range changes are held back until the next nominal-period boundary, so that a reconfiguration cannot cut a pulse short. A synchronous reset clears the timebase and holds every output low.

Top module: `skew_clock_matrix`

## Requirements
- R1: At every clock edge where `rst` is sampled high, all eight outputs become 0, and the tick phase and the period count return to 0. The first edge with `rst` low then processes tick phase 0.
- R2: Within each section, `out_a[i]` and `out_b[i]` are equal on every cycle.
- R3: Each 2-bit select code decodes as follows: 00 is LOW (level 0), 01 is MID (level 1), 10 is HIGH (level 2), and 11 is also MID, which models an open input.
- R4: The range select gives the nominal period N: LOW gives 44 ticks, MID gives 26 and HIGH gives 16. At tick phase p, the nominal clock is high when p >= N/2. An output registers its value at the edge that processes its phase.
- R5: In sections 0 and 1, the select index is idx = 3*level(F1) + level(F0). The skew is s = idx - 4. The output equals the nominal clock evaluated at phase (p - s) mod N, so a positive skew is a delay.
- R6: In sections 2 and 3, an index from 1 to 7 selects the skew s = 2*idx - 8, which runs from -6 to +6. The phase rule of R5 applies.
- R7: In sections 2 and 3, index 0 selects divide-by-2. The output is high during odd nominal periods, counting from period 0 after reset.
- R8: In section 2, index 8 selects divide-by-4. The output is high during periods whose count mod 4 is 2 or 3.
- R9: In section 3, index 8 selects the inverted nominal clock: the output is high when p < N/2.
- R10: Select and range inputs are captured only at reset and at the edge that ends a nominal period. They govern the output from phase 0 of the following period. The period count keeps running across a range change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-unit tick clock |
| rst | input | 1 | Synchronous reset, active high |
| range_sel | input | 2 | Three-level range select code (R3 encoding) |
| fsel_hi | input | 8 | Major function select per section, bits [2i+1:2i] for section i |
| fsel_lo | input | 8 | Minor function select per section, bits [2i+1:2i] for section i |
| out_a | output | 4 | First output of each section, bit i for section i |
| out_b | output | 4 | Second output of each section, bit i for section i |

## Verification
The bench keeps a tick-accurate reference model and compares every output on every cycle. It changes selects in the middle of a period, and a design that applied them at once would show a skew jump and a runt pulse before the boundary. It drives range changes across boundaries, where a design that reloaded N too early or reset the period count would break the divider phases. It also covers the open code 11, the extreme skews that wrap the phase arithmetic around zero, and the two section-specific HIGH/HIGH modes, which a shared decoder would swap.

// File: rtl/skew_clock_pkg.sv
package skew_clock_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_HIGH = 2'd2
  } level_e;

  typedef enum logic [1:0] {
    MODE_SKEW = 2'd0,
    MODE_DIV2 = 2'd1,
    MODE_DIV4 = 2'd2,
    MODE_INV  = 2'd3
  } out_mode_e;

  // Section flavours, chosen per section by the top-level generate.
  localparam int KIND_FINE     = 0;
  localparam int KIND_COARSE_Q = 1;
  localparam int KIND_COARSE_I = 2;

  localparam int DEF_PER_LOW  = 44;
  localparam int DEF_PER_MID  = 26;
  localparam int DEF_PER_HIGH = 16;

  // The 11 code stands for a floating pin, which settles at mid level.
  function automatic level_e level_of(input logic [1:0] code);
    case (code)
      2'b00:   return LVL_LOW;
      2'b10:   return LVL_HIGH;
      default: return LVL_MID;
    endcase
  endfunction

endpackage

// File: rtl/skew_timebase.sv
module skew_timebase
  import skew_clock_pkg::*;
#(
  parameter int PER_LOW  = DEF_PER_LOW,
  parameter int PER_MID  = DEF_PER_MID,
  parameter int PER_HIGH = DEF_PER_HIGH,
  parameter int CW       = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    range_code,
  output logic [CW-1:0] tc,
  output logic [CW-1:0] period,
  output logic [1:0]    pcount,
  output logic          load
);

  logic          wrap;
  logic [CW-1:0] req_period;

  always_comb begin
    case (level_of(range_code))
      LVL_LOW:  req_period = CW'(PER_LOW);
      LVL_HIGH: req_period = CW'(PER_HIGH);
      default:  req_period = CW'(PER_MID);
    endcase
  end

  assign wrap = (tc == period - CW'(1));
  assign load = rst | wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc     <= '0;
      pcount <= '0;
      period <= req_period;
    end else if (wrap) begin
      tc     <= '0;
      pcount <= pcount + 2'd1;
      period <= req_period;
    end else begin
      tc <= tc + CW'(1);
    end
  end

  p_tc_bound_r4: assert property (@(posedge clk) disable iff (rst)
    tc < period);

  p_period_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (period == CW'(PER_LOW)) || (period == CW'(PER_MID)) || (period == CW'(PER_HIGH)));

  p_wrap_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (tc == period - CW'(1)) |=> (tc == '0));

endmodule

// File: rtl/skew_section.sv
module skew_section
  import skew_clock_pkg::*;
#(
  parameter int KIND = KIND_FINE,
  parameter int CW   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [1:0]    f_major,
  input  logic [1:0]    f_minor,
  input  logic [CW-1:0] tc,
  input  logic [CW-1:0] period,
  input  logic [1:0]    pcount,
  output logic [1:0]    q
);

  logic [3:0]        idx;
  out_mode_e         dec_mode;
  logic signed [3:0] dec_skew;
  logic signed [4:0] s5;
  out_mode_e         act_mode;
  logic signed [3:0] act_skew;
  int                ph_t;
  logic              half_hi;
  logic              out_nxt;
  logic              out_r;

  // Nine-way index from the two three-level selects, major digit first.
  assign idx = {2'b00, level_of(f_major)} * 4'd3 + {2'b00, level_of(f_minor)};

  generate
    if (KIND == KIND_FINE) begin : g_fine
      always_comb begin
        s5       = $signed({1'b0, idx}) - 5'sd4;
        dec_mode = MODE_SKEW;
        dec_skew = s5[3:0];
      end
    end else begin : g_coarse
      always_comb begin
        s5       = $signed({idx, 1'b0}) - 5'sd8;
        dec_skew = s5[3:0];
        if (idx == 4'd0)
          dec_mode = MODE_DIV2;
        else if (idx == 4'd8)
          dec_mode = (KIND == KIND_COARSE_Q) ? MODE_DIV4 : MODE_INV;
        else
          dec_mode = MODE_SKEW;
      end
    end
  endgenerate

  // Shifted phase, (tc - skew) mod period, kept positive by adding one period.
  always_comb begin
    ph_t = int'(tc) + int'(period) - int'(act_skew);
    if (ph_t >= int'(period)) ph_t = ph_t - int'(period);
    if (ph_t >= int'(period)) ph_t = ph_t - int'(period);
    half_hi = (int'(tc) >= int'(period) / 2);
    case (act_mode)
      MODE_DIV2: out_nxt = pcount[0];
      MODE_DIV4: out_nxt = pcount[1];
      MODE_INV:  out_nxt = ~half_hi;
      default:   out_nxt = (ph_t >= int'(period) / 2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (load) begin
      act_mode <= dec_mode;
      act_skew <= dec_skew;
    end
    if (rst) out_r <= 1'b0;
    else     out_r <= out_nxt;
  end

  assign q = {out_r, out_r};

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(act_mode) && $stable(act_skew)));

  generate
    if (KIND != KIND_FINE) begin : g_chk_coarse
      p_coarse_even_r6: assert property (@(posedge clk) disable iff (rst)
        (act_mode == MODE_SKEW) |-> (act_skew[0] == 1'b0));
    end else begin : g_chk_fine
      p_fine_mode_r5: assert property (@(posedge clk) disable iff (rst)
        act_mode == MODE_SKEW);
    end
  endgenerate

endmodule

// File: rtl/skew_clock_matrix.sv
module skew_clock_matrix
  import skew_clock_pkg::*;
#(
  parameter int PER_LOW  = DEF_PER_LOW,
  parameter int PER_MID  = DEF_PER_MID,
  parameter int PER_HIGH = DEF_PER_HIGH
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] range_sel,
  input  logic [7:0] fsel_hi,
  input  logic [7:0] fsel_lo,
  output logic [3:0] out_a,
  output logic [3:0] out_b
);

  localparam int NSEC   = 4;
  localparam int PER_MX = (PER_LOW > PER_MID) ?
                          ((PER_LOW > PER_HIGH) ? PER_LOW : PER_HIGH) :
                          ((PER_MID > PER_HIGH) ? PER_MID : PER_HIGH);
  localparam int CW     = $clog2(PER_MX + 7) + 1;

  logic [CW-1:0] tc;
  logic [CW-1:0] period;
  logic [1:0]    pcount;
  logic          load;

  skew_timebase #(
    .PER_LOW (PER_LOW),
    .PER_MID (PER_MID),
    .PER_HIGH(PER_HIGH),
    .CW      (CW)
  ) u_tb (
    .clk       (clk),
    .rst       (rst),
    .range_code(range_sel),
    .tc        (tc),
    .period    (period),
    .pcount    (pcount),
    .load      (load)
  );

  generate
    for (genvar i = 0; i < NSEC; i++) begin : g_sec
      localparam int KIND = (i < 2) ? KIND_FINE :
                            ((i == 2) ? KIND_COARSE_Q : KIND_COARSE_I);
      logic [1:0] pair;

      skew_section #(
        .KIND(KIND),
        .CW  (CW)
      ) u_sec (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .f_major(fsel_hi[2*i +: 2]),
        .f_minor(fsel_lo[2*i +: 2]),
        .tc     (tc),
        .period (period),
        .pcount (pcount),
        .q      (pair)
      );

      assign out_a[i] = pair[0];
      assign out_b[i] = pair[1];
    end
  endgenerate

endmodule

// File: tb/tb_skew_clock_matrix.sv
`timescale 1ns/1ps
module tb_skew_clock_matrix;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] range_sel;
  logic [7:0] fsel_hi;
  logic [7:0] fsel_lo;
  logic [3:0] out_a;
  logic [3:0] out_b;

  always #2.5 clk = ~clk;

  skew_clock_matrix dut (
    .clk(clk), .rst(rst), .range_sel(range_sel),
    .fsel_hi(fsel_hi), .fsel_lo(fsel_lo), .out_a(out_a), .out_b(out_b)
  );

  int checks = 0;
  int failures = 0;

  // Reference model state.
  int    m_tc, m_pc, m_per;
  int    m_idx [4];
  logic [3:0] exp_q = 4'b0;
  string exp_tag [4];
  bit    m_valid = 1'b0;

  function automatic int lvl(input logic [1:0] c);
    if (c == 2'b00) return 0;
    if (c == 2'b10) return 2;
    return 1;                         // R3: 01 and 11 both mid
  endfunction

  function automatic int per_of(input logic [1:0] c);
    int l = lvl(c);
    return (l == 0) ? 44 : ((l == 1) ? 26 : 16);   // R4
  endfunction

  function automatic int idx_of(input int s);
    return 3 * lvl(fsel_hi[2*s +: 2]) + lvl(fsel_lo[2*s +: 2]);
  endfunction

  function automatic logic nom_at(input int p, input int n);
    return (p >= n / 2);
  endfunction

  task automatic model_bit(input int s, output logic b, output string tag);
    int sk;
    int p;
    if (s < 2) begin
      sk = m_idx[s] - 4; tag = "R5";
    end else if (m_idx[s] == 0) begin
      b = m_pc[0]; tag = "R7"; return;
    end else if (m_idx[s] == 8) begin
      if (s == 2) begin b = m_pc[1]; tag = "R8"; end
      else begin b = !nom_at(m_tc, m_per); tag = "R9"; end
      return;
    end else begin
      sk = 2 * m_idx[s] - 8; tag = "R6";
    end
    p = ((m_tc - sk) % m_per + m_per) % m_per;
    b = nom_at(p, m_per);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_tc = 0; m_pc = 0; m_per = per_of(range_sel);
      for (int s = 0; s < 4; s++) begin m_idx[s] = idx_of(s); exp_tag[s] = "R1"; end
      exp_q = 4'b0;
      m_valid = 1'b1;
    end else if (m_valid) begin
      for (int s = 0; s < 4; s++) begin
        logic b; string t;
        model_bit(s, b, t);
        exp_q[s] = b; exp_tag[s] = t;
      end
      if (m_tc == m_per - 1) begin           // R10 boundary capture
        m_tc = 0; m_pc = (m_pc + 1) % 4; m_per = per_of(range_sel);
        for (int s = 0; s < 4; s++) m_idx[s] = idx_of(s);
      end else begin
        m_tc = m_tc + 1;
      end
    end
  end

  task automatic check_outputs(input string phase);
    for (int s = 0; s < 4; s++) begin
      checks++;
      if (out_a[s] !== exp_q[s]) begin
        failures++;
        $display("FAIL %s [%s] sec%0d out_a actual=%b expected=%b", exp_tag[s], phase, s, out_a[s], exp_q[s]);
      end
      checks++;
      if (out_b[s] !== out_a[s]) begin
        failures++;
        $display("FAIL R2 [%s] sec%0d out_b actual=%b expected=%b", phase, s, out_b[s], out_a[s]);
      end
    end
  endtask

  task automatic run(input int n, input string phase);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_outputs(phase);
    end
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      checks++;
      if (out_a !== 4'b0 || out_b !== 4'b0) begin
        failures++;
        $display("FAIL R1 reset outputs actual=%b/%b expected=0000/0000", out_a, out_b);
      end
    end
    rst = 1'b0;
  endtask

  // Measure rising-edge spacing of section 0 at zero skew.
  task automatic measure_period(input logic [1:0] rc, input int n_exp);
    int last_rise;
    int gap;
    logic prev;
    range_sel = rc; fsel_hi = 8'h55; fsel_lo = 8'h55;
    do_reset(2);
    last_rise = -1; gap = -1; prev = 1'b0;
    for (int k = 0; k < 3 * n_exp; k++) begin
      @(negedge clk);
      check_outputs("R4");
      if (out_a[0] && !prev) begin
        if (last_rise >= 0 && gap < 0) gap = k - last_rise;
        last_rise = k;
      end
      prev = out_a[0];
    end
    checks++;
    if (gap != n_exp) begin
      failures++;
      $display("FAIL R4 period for range %b actual=%0d expected=%0d", rc, gap, n_exp);
    end
  endtask

  initial begin
    #1ms;
    failures++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; range_sel = 2'b10; fsel_hi = 8'h00; fsel_lo = 8'h00;
    do_reset(3);
    run(70, "R1");

    // R4: period length per range
    measure_period(2'b00, 44);
    measure_period(2'b01, 26);
    measure_period(2'b10, 16);

    // R5/R6/R7/R8/R9: sweep every index on all sections, HIGH and LOW ranges
    for (int rr = 0; rr < 2; rr++) begin
      for (int ix = 0; ix < 9; ix++) begin
        logic [1:0] hi, lo;
        hi = 2'(ix / 3); lo = 2'(ix % 3);
        range_sel = (rr == 0) ? 2'b10 : 2'b00;
        fsel_hi = {4{hi}}; fsel_lo = {4{lo}};
        do_reset(1);
        run((rr == 0) ? 70 : 180, "sweep");
      end
    end

    // R3: open code 11 must act as mid (idx 4 with 11/11, range 11 = 26)
    range_sel = 2'b11; fsel_hi = 8'hFF; fsel_lo = 8'hFF;
    do_reset(1);
    run(60, "R3");
    fsel_hi = 8'hF3; fsel_lo = 8'h3C;
    run(60, "R3");

    // R10: mid-period select and range changes wait for the boundary
    range_sel = 2'b01; fsel_hi = 8'h55; fsel_lo = 8'h55;
    do_reset(1);
    run(7, "R10");
    fsel_hi = 8'h00; fsel_lo = 8'h00;
    run(30, "R10");
    range_sel = 2'b10;
    run(9, "R10");
    range_sel = 2'b00; fsel_hi = 8'hAA; fsel_lo = 8'hAA;
    run(120, "R10");

    // Constrained random mix
    for (int seg = 0; seg < 40; seg++) begin
      range_sel = 2'($urandom_range(0, 3));
      fsel_hi = 8'($urandom);
      fsel_lo = 8'($urandom);
      if ($urandom_range(0, 5) == 0) do_reset(1);
      run($urandom_range(1, 150), "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule